// File: doc/BRIEF.md
# Device and Collection Table Walker

This block turns an identifier (a device number or a collection number) into the memory location of its table entry and returns the 64-bit entry read from there. The table can be a single contiguous array or a two-level structure. In the two-level case, a level-1 array of 8-byte descriptors points to level-2 pages that hold the entries. A configuration bit selects the organisation. A page-size code and an entry-size exponent set the geometry. Configuration must stay stable while a walk is in progress.

One walk runs at a time. The client presents an ID on the request port. The walker issues one or two reads on its 64-bit memory read port. It then pulses a response carrying the raw entry and a hit flag. The controller is a four-state machine. IDLE waits for a request. L1_FETCH reads the level-1 descriptor. ENT_FETCH reads the final entry. REPLY presents the result for one cycle. The transitions are as follows. IDLE goes to L1_FETCH in two-level mode and to ENT_FETCH in flat mode. L1_FETCH goes to ENT_FETCH on a valid descriptor, and to REPLY on an invalid descriptor or a memory fault. ENT_FETCH goes to REPLY on the memory acknowledge. REPLY always returns to IDLE.

Top module: `tbl_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0.
- R2: In flat mode (cfg_two_level=0) exactly one read is made, at cfg_base + ID × 2^cfg_esz_lg.
- R3: In two-level mode the first read is at cfg_base + (ID / (P / 8)) × 8. P is the page size in bytes: 4096 for cfg_pgsz=0, 16384 for 1, and 65536 for both 2 and 3.
- R4: If bit 63 of the level-1 descriptor is 0, no second read is made, rsp_hit is 0 and rsp_entry is 0.
- R5: For a valid descriptor D, the level-2 base is (D >> cfg_pgsz) masked to its low (51 − cfg_pgsz) bits. The second read is at that base + (ID mod (P / 2^cfg_esz_lg)) × 2^cfg_esz_lg.
- R6: When the final read completes without fault, rsp_entry equals the data read, and rsp_hit equals bit 0 of that data.
- R7: A read answered with mem_fault=1 ends the walk at once: no further read is made, rsp_hit is 0 and rsp_entry is 0.
- R8: mem_req stays high with mem_addr unchanged from the cycle it rises until the cycle mem_ack is sampled high.
- R9: req_ready falls in the cycle after a request is accepted and stays low until the walk ends. rsp_valid is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_id | input | ID_W | Identifier to resolve |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Entry found and its bit 0 set |
| rsp_entry | output | 64 | Entry data (zero on fault or invalid descriptor) |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | AW | Byte address of the read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| mem_fault | input | 1 | Read ended in error (qualified by mem_ack) |
| cfg_base | input | AW | Table base address |
| cfg_pgsz | input | 2 | Page-size code |
| cfg_esz_lg | input | 3 | log2 of entry size in bytes (3 to 7) |
| cfg_two_level | input | 1 | 1 selects the two-level organisation |

## Verification
The hardest case to reach is a fault on the second read that follows a valid descriptor. Reaching it requires the descriptor to be valid, the level-2 base to decode correctly, and the error to land exactly on the computed entry address. The bench computes that address with its own arithmetic and arms the memory model's fault address to it, so the walk passes the valid gate before it fails. Page-boundary IDs (the last slot of one level-2 page and the first of the next) are chosen so that the division and modulo paths switch descriptors between adjacent requests. Memory latency is varied so that the hold of address and request is exercised across several waiting cycles.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        TW_IDLE,
        TW_L1,
        TW_ENT,
        TW_REPLY
    } tw_state_e;

    // log2 of page size in bytes for a page-size code; code 3 maps to 64 KB
    function automatic logic [4:0] page_log2(input logic [1:0] code);
        unique case (code)
            2'd0:    page_log2 = 5'd12;
            2'd1:    page_log2 = 5'd14;
            default: page_log2 = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
    import tw_pkg::*;
#(
    parameter int ID_W = 20,
    parameter int AW   = 52
) (
    input  logic [AW-1:0]   base,
    input  logic [ID_W-1:0] id,
    input  logic [1:0]      pgsz,
    input  logic [2:0]      esz_lg,
    input  logic            two_level,
    input  logic [AW-1:0]   l2_base,
    output logic [AW-1:0]   l1_addr,
    output logic [AW-1:0]   ent_addr
);
    localparam int DESC_LG = 3;

    logic [4:0]  pg_lg;
    logic [5:0]  slots_lg;
    logic [63:0] id64, base64, l2b64;
    logic [63:0] l1_idx, slot_mask, l2_off, flat_addr;

    always_comb begin
        pg_lg     = page_log2(pgsz);
        slots_lg  = {1'b0, pg_lg} - {3'b000, esz_lg};
        id64      = 64'(id);
        base64    = 64'(base);
        l2b64     = 64'(l2_base);
        l1_idx    = id64 >> (pg_lg - 5'(DESC_LG));
        l1_addr   = AW'(base64 + (l1_idx << DESC_LG));
        slot_mask = (64'd1 << slots_lg) - 64'd1;
        l2_off    = (id64 & slot_mask) << esz_lg;
        flat_addr = base64 + (id64 << esz_lg);
        ent_addr  = AW'(two_level ? (l2b64 + l2_off) : flat_addr);
    end
endmodule

// File: rtl/tw_desc_dec.sv
module tw_desc_dec #(
    parameter int AW = 52
) (
    input  logic [63:0]   desc,
    input  logic [1:0]    pgsz,
    output logic          valid,
    output logic [AW-1:0] l2_base
);
    localparam int VBIT    = 63;
    localparam int KEEP_LG = 51;

    logic [5:0]  keep;
    logic [63:0] shifted;

    always_comb begin
        valid   = desc[VBIT];
        keep    = 6'(KEEP_LG) - {4'b0000, pgsz};
        shifted = (desc >> pgsz) & ((64'd1 << keep) - 64'd1);
        l2_base = AW'(shifted);
    end
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
    import tw_pkg::*;
#(
    parameter int ID_W = 20,
    parameter int AW   = 52
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [ID_W-1:0] req_id,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [63:0]     rsp_entry,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ack,
    input  logic [63:0]     mem_rdata,
    input  logic            mem_fault,
    input  logic [AW-1:0]   cfg_base,
    input  logic [1:0]      cfg_pgsz,
    input  logic [2:0]      cfg_esz_lg,
    input  logic            cfg_two_level
);
    tw_state_e       state, state_nx;
    logic [ID_W-1:0] id_q;
    logic [AW-1:0]   l2_q;
    logic [63:0]     entry_q;
    logic            hit_q;
    logic [AW-1:0]   l1_addr, ent_addr, dec_l2;
    logic            dec_valid;
    logic            accept;

    tw_addr_gen #(.ID_W(ID_W), .AW(AW)) u_addr (
        .base(cfg_base), .id(id_q), .pgsz(cfg_pgsz), .esz_lg(cfg_esz_lg),
        .two_level(cfg_two_level), .l2_base(l2_q),
        .l1_addr(l1_addr), .ent_addr(ent_addr)
    );

    tw_desc_dec #(.AW(AW)) u_dec (
        .desc(mem_rdata), .pgsz(cfg_pgsz), .valid(dec_valid), .l2_base(dec_l2)
    );

    assign accept = req_valid && (state == TW_IDLE);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            TW_IDLE:  if (req_valid) state_nx = cfg_two_level ? TW_L1 : TW_ENT;
            TW_L1:    if (mem_ack)   state_nx = (mem_fault || !dec_valid) ? TW_REPLY : TW_ENT;
            TW_ENT:   if (mem_ack)   state_nx = TW_REPLY;
            TW_REPLY: state_nx = TW_IDLE;
            default:  state_nx = TW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TW_IDLE;
        else        state <= state_nx;
    end

    // walk data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q    <= '0;
            l2_q    <= '0;
            entry_q <= '0;
            hit_q   <= 1'b0;
        end else begin
            if (accept) begin
                id_q    <= req_id;
                entry_q <= '0;
                hit_q   <= 1'b0;
            end
            if (state == TW_L1 && mem_ack && !mem_fault) l2_q <= dec_l2;
            if (state == TW_ENT && mem_ack) begin
                entry_q <= mem_fault ? 64'd0 : mem_rdata;
                hit_q   <= !mem_fault && mem_rdata[0];
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == TW_IDLE);
        rsp_valid = (state == TW_REPLY);
        rsp_hit   = rsp_valid && hit_q;
        rsp_entry = rsp_valid ? entry_q : 64'd0;
        mem_req   = (state == TW_L1) || (state == TW_ENT);
        mem_addr  = (state == TW_L1) ? l1_addr : ent_addr;
    end

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    hit_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && rsp_entry[0]));

    // R7
    fault_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_fault) |=> (rsp_valid && !rsp_hit && rsp_entry == 64'd0));

    // R4
    l1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TW_L1 && mem_ack && !mem_fault && !mem_rdata[63])
            |=> (rsp_valid && !rsp_hit && !mem_req));
endmodule

// File: tb/sim_tbl_walker.sv
module sim_tbl_walker;
    localparam int ID_W = 20;
    localparam int AW   = 52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [ID_W-1:0] req_id = '0;
    logic            rsp_valid, rsp_hit;
    logic [63:0]     rsp_entry;
    logic            mem_req;
    logic [AW-1:0]   mem_addr;
    logic            mem_ack = 1'b0;
    logic [63:0]     mem_rdata = '0;
    logic            mem_fault = 1'b0;
    logic [AW-1:0]   cfg_base = '0;
    logic [1:0]      cfg_pgsz = '0;
    logic [2:0]      cfg_esz_lg = 3'd3;
    logic            cfg_two_level = 1'b0;

    tbl_walker #(.ID_W(ID_W), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_entry(rsp_entry),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault), .cfg_base(cfg_base), .cfg_pgsz(cfg_pgsz),
        .cfg_esz_lg(cfg_esz_lg), .cfg_two_level(cfg_two_level)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // sparse memory model
    logic [63:0] mem [logic [AW-1:0]];
    logic [AW-1:0] fault_addr = '1;
    int           lat = 0;
    int           cnt = 0;
    int           nrd = 0;
    logic [AW-1:0] last_addr = '0;
    logic [AW-1:0] first_addr = '0;

    function automatic logic [63:0] rd(input logic [AW-1:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_fault = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            if (cnt == 0) first_addr = mem_addr;
            if (cnt >= lat) begin
                check("R8", "address held until acknowledge", 64'(mem_addr), 64'(first_addr));
                nrd++;
                last_addr = mem_addr;
                mem_rdata = rd(mem_addr);
                mem_fault = (mem_addr == fault_addr);
                mem_ack   = 1'b1;
                cnt = 0;
            end else begin
                cnt++;
            end
        end
    end

    typedef struct {
        bit            hit;
        logic [63:0]   entry;
        int            nreads;
        logic [AW-1:0] last;
        string         tag;
    } exp_t;

    exp_t q[$];

    function automatic longint unsigned page_bytes();
        case (cfg_pgsz)
            2'd0: return 64'd4096;
            2'd1: return 64'd16384;
            default: return 64'd65536;
        endcase
    endfunction

    function automatic logic [AW-1:0] l1_of(input int id);
        return AW'(64'(cfg_base) + (64'(id) / (page_bytes() / 8)) * 8);
    endfunction

    function automatic exp_t predict(input int id, input string tag);
        exp_t e;
        longint unsigned esz, d, l2, a2;
        logic [AW-1:0] a1;
        esz = 64'd1 << cfg_esz_lg;
        e.tag = tag; e.hit = 0; e.entry = 0;
        if (!cfg_two_level) begin
            a2 = 64'(cfg_base) + 64'(id) * esz;
            e.nreads = 1; e.last = AW'(a2);
        end else begin
            a1 = l1_of(id);
            e.nreads = 1; e.last = a1;
            if (a1 == fault_addr) return e;
            d = rd(a1);
            if (!d[63]) return e;
            l2 = (d >> cfg_pgsz) & ((64'd1 << (51 - cfg_pgsz)) - 1);
            a2 = l2 + (64'(id) % (page_bytes() / esz)) * esz;
            e.nreads = 2; e.last = AW'(a2);
        end
        if (AW'(a2) == fault_addr) return e;
        e.entry = rd(AW'(a2));
        e.hit = e.entry[0];
        return e;
    endfunction

    function automatic logic [AW-1:0] ent_of(input int id);
        longint unsigned esz, d, l2;
        esz = 64'd1 << cfg_esz_lg;
        if (!cfg_two_level) return AW'(64'(cfg_base) + 64'(id) * esz);
        d  = rd(l1_of(id));
        l2 = (d >> cfg_pgsz) & ((64'd1 << (51 - cfg_pgsz)) - 1);
        return AW'(l2 + (64'(id) % (page_bytes() / esz)) * esz);
    endfunction

    // install descriptor (if missing) and entry for an id under current config
    task automatic map_id(input int id, input logic [63:0] val);
        logic [AW-1:0] a1;
        longint unsigned l2;
        if (cfg_two_level) begin
            a1 = l1_of(id);
            if (!mem.exists(a1)) begin
                l2 = 64'h4000_0000 + (64'(a1) << 16);
                mem[a1] = (64'd1 << 63) | (l2 << cfg_pgsz);
            end
        end
        mem[ent_of(id)] = val;
    endtask

    task automatic run(input int id, input string tag);
        while (!req_ready) @(negedge clk);
        nrd = 0;
        q.push_back(predict(id, tag));
        req_valid = 1'b1;
        req_id = ID_W'(id);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "busy after accept", 64'(req_ready), 64'd0);
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        check("R9", "single response strobe", 64'(rsp_valid), 64'd0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (q.size() == 0) begin
                check("R9", "unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "hit", 64'(rsp_hit), 64'(e.hit));
                check(e.tag, "entry", rsp_entry, e.entry);
                check(e.tag, "read count", 64'(nrd), 64'(e.nreads));
                check(e.tag, "last address", 64'(last_addr), 64'(e.last));
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "req_ready in reset", 64'(req_ready), 64'd1);
        check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R1", "mem_req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", 64'(mem_req), 64'd0);

        // R2 flat, 8-byte entries
        cfg_two_level = 0; cfg_base = 52'h10000; cfg_esz_lg = 3'd3; lat = 0;
        map_id(5, 64'hABCD_0000_0000_0001);
        run(5, "R2");
        // R6 flat, 32-byte entries, entry bit 0 clear
        cfg_esz_lg = 3'd5; lat = 2;
        map_id(3, 64'h1234_5678_9ABC_DEF0);
        run(3, "R6");

        // R3/R5 two-level, each page-size code
        cfg_two_level = 1; cfg_base = 52'h20000; cfg_pgsz = 2'd0; cfg_esz_lg = 3'd3; lat = 1;
        map_id(1000, 64'h0000_0000_0000_1001);
        run(1000, "R3");
        cfg_base = 52'h30000; cfg_pgsz = 2'd1; cfg_esz_lg = 3'd4; lat = 3;
        map_id(5000, 64'h0000_0000_0000_5001);
        run(5000, "R5");
        cfg_base = 52'h40000; cfg_pgsz = 2'd2; cfg_esz_lg = 3'd3; lat = 0;
        map_id(70000, 64'h7777_0000_0000_0001);
        run(70000, "R3");
        cfg_base = 52'h50000; cfg_pgsz = 2'd3; cfg_esz_lg = 3'd3; lat = 2;
        map_id(9000, 64'h9000_0000_0000_0003);
        run(9000, "R3");

        // R5 page boundary: last slot of one page, first of the next
        cfg_base = 52'h60000; cfg_pgsz = 2'd0; cfg_esz_lg = 3'd3; lat = 1;
        map_id(511, 64'h0000_0000_0511_0001);
        map_id(512, 64'h0000_0000_0512_0001);
        run(511, "R5");
        run(512, "R5");

        // R4 invalid level-1 descriptor (index 5 never installed)
        lat = 0;
        run(2560, "R4");

        // R7 fault on level-1 read
        fault_addr = l1_of(1000 - 512 + 512);
        run(1000, "R7");
        // R7 fault on final read after valid descriptor
        fault_addr = ent_of(511);
        lat = 2;
        run(511, "R7");
        fault_addr = '1;
        // R7 fault on flat read
        cfg_two_level = 0; cfg_base = 52'h10000; cfg_esz_lg = 3'd3;
        fault_addr = ent_of(5);
        run(5, "R7");
        fault_addr = '1;
        run(5, "R2");

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule